// File: doc/BRIEF.md
# Interrupt State Bitmap Bank

This block stores five per-line flag sets for up to 1024 interrupt lines: enable, pending, active, group and group modifier. The first three are reached through pairs of 32-bit windows. A write to the "raise" window turns on every bit written as 1. A write to the "drop" window turns off every bit written as 1. Either window of a pair reads back the present flags.

Group and group-modifier flags are plain read/write words. They are gated by the security attribute of the access and by an external security-disable level. The words that cover lines 0..31 read as zero and drop writes, and so do all words past the implemented line count.

Each access is a single-cycle request. Read data comes back one cycle later. When a write alters state, or is accepted into a group word, the block raises a one-cycle update strobe. The strobe carries the first line of the affected 32-line word and the line count, so that a downstream priority stage can re-evaluate only those lines.

Top module: `irqbank_top`

## Requirements
- R1: A read request (`req_valid`=1, `req_write`=0) yields `rd_valid`=1 on the next cycle with the addressed word on `rd_data`. Otherwise `rd_valid` is 0.
- R2: `req_addr[8:5]` selects the window and `req_addr[4:0]` selects the 32-line word. Window codes are: 0 enable raise, 1 enable drop, 2 pending raise, 3 pending drop, 4 active raise, 5 active drop, 6 group, 7 group modifier. Codes 8..15 read as zero and ignore writes.
- R3: A write to a raise window ORs `req_wdata` into the addressed word of that state.
- R4: A write to a drop window clears, in the addressed word, each bit that is 1 in `req_wdata`. Other bits are unchanged.
- R5: Both windows of a pair read the same present word. The enable, pending and active states never affect each other.
- R6: Raise and drop windows for words at or above `NUM_IRQ/32` read as zero and ignore writes.
- R7: The group word reads as zero and ignores writes when `req_secure`=0, unless `sec_disable`=1.
- R8: The group-modifier word reads as zero and ignores writes when `sec_disable`=1 or `req_secure`=0.
- R9: Group and group-modifier word 0 (lines below 32) and words at or above `NUM_IRQ/32` read as zero and ignore writes, whatever the security state.
- R10: A raise or drop write that changes at least one bit gives, on the next cycle, `upd_valid`=1 with `upd_base`=word*32 and `upd_count`=32. A write that changes nothing gives no strobe.
- R11: An accepted group or group-modifier write gives the same strobe even if the value is unchanged. A rejected write gives none.
- R12: After reset all states are zero, and `rd_valid` and `upd_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_disable | input | 1 | Security-disable level from the control register |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute of the access |
| req_addr | input | 9 | Word address: window [8:5], word [4:0] |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| upd_valid | output | 1 | One-cycle update strobe |
| upd_base | output | 10 | First line of the updated range |
| upd_count | output | 6 | Number of lines in the updated range |

## Verification
The bench builds the block with `NUM_IRQ`=128, which gives four implemented words. Word addresses 4..31 then lie past the implemented range, so R6 and R9 can be probed at both ends of the range: word 0, and the first and last out-of-range words. Both security inputs are swept across the gating cases of the group and group-modifier words. A long stretch of pseudo-random accesses mixes every window code, including the unused codes.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    localparam int LINES_PER_WORD = 32;
    localparam int MAX_WORDS      = 32;
    localparam int ADDR_W         = 9;
    localparam int BASE_W         = 10;
    localparam int CNT_W          = 6;
    localparam int NUM_MAPS       = 5;

    typedef enum logic [3:0] {
        WIN_EN_RAISE = 4'd0,
        WIN_EN_DROP  = 4'd1,
        WIN_PD_RAISE = 4'd2,
        WIN_PD_DROP  = 4'd3,
        WIN_AC_RAISE = 4'd4,
        WIN_AC_DROP  = 4'd5,
        WIN_GROUP    = 4'd6,
        WIN_GMOD     = 4'd7
    } win_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_RAISE = 2'd1,
        OP_DROP  = 2'd2,
        OP_LOAD  = 2'd3
    } map_op_e;

    typedef struct packed {
        logic              rd_valid;
        logic [31:0]       rd_data;
        logic              upd_valid;
        logic [BASE_W-1:0] upd_base;
    } out_regs_t;

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int NWORDS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_write,
    input  logic              secure,
    input  logic              sec_disable,
    output logic [2:0]        map_sel,
    output map_op_e           op,
    output logic [4:0]        word,
    output logic              access_ok
);
    logic [3:0] win;
    logic       in_impl;
    logic       above_low;

    always_comb begin
        win       = addr[8:5];
        word      = addr[4:0];
        in_impl   = int'(word) < NWORDS;
        above_low = word != 5'd0;
        map_sel   = 3'd0;
        op        = OP_NONE;
        access_ok = 1'b0;
        case (win)
            WIN_EN_RAISE, WIN_EN_DROP,
            WIN_PD_RAISE, WIN_PD_DROP,
            WIN_AC_RAISE, WIN_AC_DROP: begin
                map_sel   = {1'b0, win[2:1]};
                access_ok = in_impl;
                op        = win[0] ? OP_DROP : OP_RAISE;
            end
            WIN_GROUP: begin
                map_sel   = 3'd3;
                access_ok = in_impl && above_low && (secure || sec_disable);
                op        = OP_LOAD;
            end
            WIN_GMOD: begin
                map_sel   = 3'd4;
                access_ok = in_impl && above_low && secure && !sec_disable;
                op        = OP_LOAD;
            end
            default: begin
                map_sel   = 3'd0;
                access_ok = 1'b0;
                op        = OP_NONE;
            end
        endcase
        if (!is_write || !access_ok) begin
            op = OP_NONE;
        end
    end

endmodule

// File: rtl/irqbank_bitmap.sv
module irqbank_bitmap
    import irqbank_pkg::*;
#(
    parameter int NWORDS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  map_op_e     op,
    input  logic [4:0]  word,
    input  logic [31:0] wdata,
    output logic [31:0] rd_word,
    output logic        hit
);
    localparam int IW = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    logic [NWORDS-1:0][31:0] map_d, map_q;
    logic [IW-1:0]           idx;
    logic                    in_rng;

    always_comb begin
        idx     = word[IW-1:0];
        in_rng  = int'(word) < NWORDS;
        map_d   = map_q;
        hit     = 1'b0;
        rd_word = in_rng ? map_q[idx] : 32'd0;
        if (in_rng && op != OP_NONE) begin
            case (op)
                OP_RAISE: map_d[idx] = map_q[idx] | wdata;
                OP_DROP:  map_d[idx] = map_q[idx] & ~wdata;
                OP_LOAD:  map_d[idx] = wdata;
                default:  map_d[idx] = map_q[idx];
            endcase
            hit = (op == OP_LOAD) || (map_d[idx] != map_q[idx]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    AST_RAISE_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RAISE) |=> (($past(map_q) & ~map_q) == '0)); // R3
    AST_DROP_ADDS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DROP) |=> ((map_q & ~$past(map_q)) == '0)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_NONE) |=> $stable(map_q)); // R5

endmodule

// File: rtl/irqbank_top.sv
module irqbank_top
    import irqbank_pkg::*;
#(
    parameter int NUM_IRQ = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_disable,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_secure,
    input  logic [8:0]        req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    output logic              upd_valid,
    output logic [9:0]        upd_base,
    output logic [5:0]        upd_count
);
    localparam int NWORDS = NUM_IRQ / LINES_PER_WORD;

    logic [2:0]  map_sel;
    map_op_e     dec_op;
    logic [4:0]  word;
    logic        access_ok;

    logic [NUM_MAPS-1:0][31:0] rd_words;
    logic [NUM_MAPS-1:0]       hits;

    out_regs_t   regs_d, regs_q;

    irqbank_decode #(.NWORDS(NWORDS)) u_decode (
        .addr        (req_addr),
        .is_write    (req_valid && req_write),
        .secure      (req_secure),
        .sec_disable (sec_disable),
        .map_sel     (map_sel),
        .op          (dec_op),
        .word        (word),
        .access_ok   (access_ok)
    );

    for (genvar g = 0; g < NUM_MAPS; g++) begin : g_map
        map_op_e map_op;
        assign map_op = (map_sel == 3'(g)) ? dec_op : OP_NONE;
        irqbank_bitmap #(.NWORDS(NWORDS)) u_map (
            .clk     (clk),
            .rst_n   (rst_n),
            .op      (map_op),
            .word    (word),
            .wdata   (req_wdata),
            .rd_word (rd_words[g]),
            .hit     (hits[g])
        );
    end

    always_comb begin
        regs_d           = regs_q;
        regs_d.rd_valid  = req_valid && !req_write;
        regs_d.rd_data   = (req_valid && !req_write && access_ok)
                           ? rd_words[map_sel] : 32'd0;
        regs_d.upd_valid = |hits;
        regs_d.upd_base  = (|hits) ? {word, 5'd0} : regs_q.upd_base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_valid  = regs_q.rd_valid;
    assign rd_data   = regs_q.rd_data;
    assign upd_valid = regs_q.upd_valid;
    assign upd_base  = regs_q.upd_base;
    assign upd_count = 6'(LINES_PER_WORD);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R1
    AST_UPD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> $past(req_valid && req_write)); // R10
    AST_UPD_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_base[4:0] == 5'd0)); // R11
    AST_GROUP_NS_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_secure && !sec_disable
         && req_addr[8:5] == WIN_GROUP) |=> (rd_data == 32'd0)); // R7
    AST_GMOD_SD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && sec_disable
         && req_addr[8:5] == WIN_GMOD) |=> (rd_data == 32'd0)); // R8
    AST_UNUSED_WIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[8] && !req_write) |=> (rd_data == 32'd0)); // R2

endmodule

// File: tb/tb_irqbank_top.sv
module tb_irqbank_top;

    localparam int NIRQ = 128;
    localparam int NW   = NIRQ / 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_disable = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_secure = 1'b0;
    logic [8:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        upd_valid;
    logic [9:0]  upd_base;
    logic [5:0]  upd_count;

    irqbank_top #(.NUM_IRQ(NIRQ)) dut (
        .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable),
        .req_valid(req_valid), .req_write(req_write), .req_secure(req_secure),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .upd_valid(upd_valid), .upd_base(upd_base), .upd_count(upd_count)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit [31:0] model [5][32];
    bit        e_rd_v = 0;
    bit [31:0] e_rd_d = 0;
    bit        e_up_v = 0;
    int        e_up_b = 0;
    string     e_tag = "R12";

    task automatic check(string tag, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        check(e_tag, "rd_valid", int'(rd_valid), int'(e_rd_v));
        if (e_rd_v) check(e_tag, "rd_data", int'(rd_data), int'(e_rd_d));
        check(e_tag, "upd_valid", int'(upd_valid), int'(e_up_v));
        if (e_up_v) begin
            check(e_tag, "upd_base", int'(upd_base), e_up_b);
            check(e_tag, "upd_count", int'(upd_count), 32);
        end
    endtask

    // reference: compute next-cycle expectations and update model state
    task automatic predict(bit v, bit w, bit sec, bit sd, int win, int wd, bit [31:0] d);
        bit        ok;
        int        m;
        bit [31:0] old;
        e_rd_v = v && !w;
        e_rd_d = 0;
        e_up_v = 0;
        if (!v) return;
        ok = 0;
        m  = 0;
        if (win <= 5) begin
            ok = wd < NW; m = win / 2;
        end else if (win == 6) begin
            ok = wd >= 1 && wd < NW && (sec || sd); m = 3;
        end else if (win == 7) begin
            ok = wd >= 1 && wd < NW && sec && !sd; m = 4;
        end
        if (!ok) return;
        if (!w) begin
            e_rd_d = model[m][wd];
            return;
        end
        old = model[m][wd];
        if (win <= 5) begin
            if (win % 2 == 0) model[m][wd] = old | d;
            else              model[m][wd] = old & ~d;
            e_up_v = model[m][wd] != old;
        end else begin
            model[m][wd] = d;
            e_up_v = 1;
        end
        e_up_b = wd * 32;
    endtask

    task automatic step(string tag, bit v, bit w, bit sec, bit sd,
                        int win, int wd, bit [31:0] d);
        @(negedge clk);
        compare();
        predict(v, w, sec, sd, win, wd, d);
        e_tag       = tag;
        req_valid   = v;
        req_write   = w;
        req_secure  = sec;
        sec_disable = sd;
        req_addr    = {4'(win), 5'(wd)};
        req_wdata   = d;
    endtask

    task automatic wr(string tag, bit sec, bit sd, int win, int wd, bit [31:0] d);
        step(tag, 1, 1, sec, sd, win, wd, d);
    endtask

    task automatic rd(string tag, bit sec, bit sd, int win, int wd);
        step(tag, 1, 0, sec, sd, win, wd, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 32; j++) model[i][j] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        for (int k = 0; k < 8; k++) rd("R12", 1, 0, k, 1);
        // R3 R1: raise enable
        wr("R3", 1, 0, 0, 0, 32'h0000_00A5);
        rd("R1", 0, 0, 0, 0);
        rd("R5", 0, 0, 1, 0);
        // R10: repeat same raise -> no strobe
        wr("R10", 1, 0, 0, 0, 32'h0000_0005);
        // R4: drop
        wr("R4", 0, 0, 1, 0, 32'h0000_0081);
        rd("R4", 0, 0, 0, 0);
        // R10: drop of clear bits -> no strobe
        wr("R10", 0, 0, 1, 0, 32'h0000_0100);
        // R5: independence
        wr("R5", 1, 0, 2, 3, 32'hDEAD_BEEF);
        wr("R5", 1, 0, 4, 2, 32'h1234_5678);
        rd("R5", 1, 0, 0, 3);
        rd("R5", 1, 0, 3, 3);
        rd("R5", 1, 0, 5, 2);
        rd("R5", 1, 0, 2, 2);
        // R6: out of range raise/drop
        wr("R6", 1, 0, 0, NW, 32'hFFFF_FFFF);
        rd("R6", 1, 0, 0, NW);
        wr("R6", 1, 0, 2, 31, 32'hFFFF_FFFF);
        rd("R6", 1, 0, 3, 31);
        // R7: group gating
        wr("R7", 0, 0, 6, 1, 32'hAAAA_0001);
        rd("R7", 1, 0, 6, 1);
        wr("R7", 1, 0, 6, 1, 32'h5555_0002);
        rd("R7", 0, 0, 6, 1);
        rd("R7", 0, 1, 6, 1);
        wr("R7", 0, 1, 6, 2, 32'h0F0F_0F0F);
        rd("R7", 1, 0, 6, 2);
        // R11: same-value group write still strobes
        wr("R11", 1, 0, 6, 2, 32'h0F0F_0F0F);
        // R8: group-modifier gating
        wr("R8", 1, 1, 7, 1, 32'hFFFF_0000);
        rd("R8", 1, 0, 7, 1);
        wr("R8", 0, 0, 7, 1, 32'hFFFF_0000);
        rd("R8", 1, 0, 7, 1);
        wr("R8", 1, 0, 7, 1, 32'h0000_FFFF);
        rd("R8", 1, 0, 7, 1);
        rd("R8", 1, 1, 7, 1);
        // R9: word 0 and above range
        wr("R9", 1, 1, 6, 0, 32'hFFFF_FFFF);
        rd("R9", 1, 1, 6, 0);
        wr("R9", 1, 0, 7, 0, 32'hFFFF_FFFF);
        rd("R9", 1, 0, 7, 0);
        wr("R9", 1, 0, 6, NW, 32'h1);
        rd("R9", 1, 0, 6, NW);
        // R2: unused window codes
        wr("R2", 1, 0, 9, 1, 32'hFFFF_FFFF);
        rd("R2", 1, 0, 9, 1);
        rd("R2", 1, 0, 15, 0);
        // R1: idle cycle
        step("R1", 0, 0, 0, 0, 0, 0, 32'h0);
        // mixed pseudo-random traffic, R2 R3 R4 R10 R11
        begin
            int seed;
            seed = 7;
            void'($urandom(seed));
        end
        for (int i = 0; i < 2000; i++) begin
            int r;
            r = $urandom;
            step("R10", r[0], r[1], r[2], r[3] & r[4], r[11:8], (r[5]) ? r[16:12] : 32'(r[13:12]), $urandom);
        end
        step("R1", 0, 0, 0, 0, 0, 0, 32'h0);
        @(negedge clk);
        compare();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule